// File: doc/BRIEF.md
# Implication-Based Concurrent Error Checker

This block monitors a bus of internal node values tapped from a combinational logic cone. It evaluates a fixed set of value implications of the form "when node A carries value x, node B must carry value y". Any implication whose antecedent holds while its consequent does not is a violation, and a violation points to a fault somewhere on the logic between the two nodes. A single implication can cover faults at several sites along that path. Each implication becomes one two-input AND term, with up to two inputs inverted. All the terms are ORed into a single error.

The implication table is set when the block is built. Each entry holds an antecedent index and value, a consequent index and value, and an enable bit. Disabled entries keep the active set within an area budget. Vectors are presented with a valid strobe. A separate input reports whether the observed outputs differ from the expected outputs for the same vector. Each vector is then classified by whether an implication fired and whether the error reached an output. One saturating counter is kept for each of the four outcomes, which lets detection coverage be measured during fault campaigns.

Top module: `impl_err_chk`

## Requirements
- R1: Implication i is violated when node ANT_IDX[8i+7:8i] equals ANT_VAL[i] and node CON_IDX[8i+7:8i] differs from CON_VAL[i]. The index fields are 8 bits wide, with entry 0 in the least significant field. Bit i of viol_vec_o shows whether implication i was violated on the most recent valid vector, and it holds while no new vector arrives.
- R2: An implication with IMP_EN[i]=0 never sets its viol_vec_o bit and never contributes to err_o.
- R3: err_o is the OR of all violations for a vector presented with valid_i. It appears one clock after that vector, in the same cycle as out_vld_o. Both are low after a cycle without valid_i.
- R4: sticky_o sets in the cycle err_o is high and stays set until clr_i is sampled high. A violation in the same cycle as clr_i leaves the flag set.
- R5: Each valid vector increments exactly one counter, in the same cycle err_o is updated. The outcomes are: true detection (out_mismatch_i=1 and a violation), false positive (no mismatch and a violation), true miss (mismatch and no violation), and benign miss (neither). Counters do not change without valid_i.
- R6: Each counter saturates at all ones and stays there.
- R7: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Vector strobe |
| nodes_i | input | NODE_W | Tapped node values |
| out_mismatch_i | input | 1 | Observed outputs differ from expected outputs |
| clr_i | input | 1 | Synchronous clear of the sticky flag |
| out_vld_o | output | 1 | Registered result valid |
| err_o | output | 1 | Registered combined violation |
| sticky_o | output | 1 | Sticky error flag |
| viol_vec_o | output | NUM_IMP | Per-implication violations of the last vector |
| cnt_true_det_o | output | CNT_W | True detection count |
| cnt_false_pos_o | output | CNT_W | False positive count |
| cnt_true_miss_o | output | CNT_W | True miss count |
| cnt_benign_o | output | CNT_W | Benign miss count |

## Verification
A fault-free cone never violates a valid implication, so random node values alone mostly exercise benign misses. To reach true detections, false positives and true misses, the stimulus derives every vector from a small gate model with an injectable stuck-at fault on a random node, and sets the mismatch input from the model's primary output. A second instance is built with 3-bit counters and every implication enabled. That instance makes saturation reachable within the run, and it shows a false implication firing where the first instance masks it.

// File: rtl/impl_chk_pkg.sv
package impl_chk_pkg;
  localparam int unsigned IDX_FIELD_W  = 8;
  localparam int unsigned NUM_OUTCOMES = 4;

  typedef enum logic [1:0] {
    OC_TRUE_DET  = 2'd0,
    OC_FALSE_POS = 2'd1,
    OC_TRUE_MISS = 2'd2,
    OC_BENIGN    = 2'd3
  } outcome_e;

  function automatic outcome_e classify(input logic fired, input logic out_err);
    unique case ({out_err, fired})
      2'b11:   return OC_TRUE_DET;
      2'b01:   return OC_FALSE_POS;
      2'b10:   return OC_TRUE_MISS;
      default: return OC_BENIGN;
    endcase
  endfunction
endpackage

// File: rtl/impl_term.sv
module impl_term #(
  parameter logic A_VAL = 1'b1,
  parameter logic C_VAL = 1'b1,
  parameter logic EN    = 1'b1
) (
  input  logic a_bit_i,
  input  logic c_bit_i,
  output logic viol_o
);
  logic a_hit, c_miss;
  assign a_hit  = A_VAL ? a_bit_i : ~a_bit_i;
  assign c_miss = C_VAL ? ~c_bit_i : c_bit_i;
  assign viol_o = a_hit & c_miss & EN;
endmodule

// File: rtl/sat_ctr.sv
module sat_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/impl_err_chk.sv
module impl_err_chk
  import impl_chk_pkg::*;
#(
  parameter int unsigned NODE_W  = 8,
  parameter int unsigned NUM_IMP = 8,
  parameter int unsigned CNT_W   = 32,
  parameter logic [NUM_IMP*IDX_FIELD_W-1:0] ANT_IDX =
    {8'd2, 8'd7, 8'd4, 8'd7, 8'd6, 8'd5, 8'd4, 8'd4},
  parameter logic [NUM_IMP*IDX_FIELD_W-1:0] CON_IDX =
    {8'd1, 8'd3, 8'd0, 8'd4, 8'd5, 8'd4, 8'd7, 8'd5},
  parameter logic [NUM_IMP-1:0] ANT_VAL = 8'b1111_1011,
  parameter logic [NUM_IMP-1:0] CON_VAL = 8'b1110_0001,
  parameter logic [NUM_IMP-1:0] IMP_EN  = 8'h7F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [NODE_W-1:0]  nodes_i,
  input  logic               out_mismatch_i,
  input  logic               clr_i,
  output logic               out_vld_o,
  output logic               err_o,
  output logic               sticky_o,
  output logic [NUM_IMP-1:0] viol_vec_o,
  output logic [CNT_W-1:0]   cnt_true_det_o,
  output logic [CNT_W-1:0]   cnt_false_pos_o,
  output logic [CNT_W-1:0]   cnt_true_miss_o,
  output logic [CNT_W-1:0]   cnt_benign_o
);
  logic [NUM_IMP-1:0] viol;
  logic               fire;

  for (genvar i = 0; i < NUM_IMP; i++) begin : g_imp
    localparam int unsigned AI = int'(ANT_IDX[i*IDX_FIELD_W +: IDX_FIELD_W]);
    localparam int unsigned CI = int'(CON_IDX[i*IDX_FIELD_W +: IDX_FIELD_W]);
    impl_term #(
      .A_VAL(ANT_VAL[i]),
      .C_VAL(CON_VAL[i]),
      .EN   (IMP_EN[i])
    ) u_term (
      .a_bit_i(nodes_i[AI]),
      .c_bit_i(nodes_i[CI]),
      .viol_o (viol[i])
    );
  end

  assign fire = |viol;

  logic               vld_q, err_q, sticky_q;
  logic [NUM_IMP-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
      vec_q    <= '0;
    end else begin
      vld_q    <= valid_i;
      err_q    <= valid_i & fire;
      // a new violation wins over a clear in the same cycle
      sticky_q <= (sticky_q & ~clr_i) | (valid_i & fire);
      if (valid_i) vec_q <= viol;
    end
  end

  outcome_e                 outcome;
  logic [NUM_OUTCOMES-1:0]  oc_hot;
  logic [CNT_W-1:0]         cnt_arr [NUM_OUTCOMES];

  assign outcome = classify(fire, out_mismatch_i);
  assign oc_hot  = NUM_OUTCOMES'(1) << outcome;

  for (genvar k = 0; k < NUM_OUTCOMES; k++) begin : g_ctr
    sat_ctr #(.W(CNT_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (valid_i & oc_hot[k]),
      .cnt_o (cnt_arr[k])
    );
  end

  assign out_vld_o       = vld_q;
  assign err_o           = err_q;
  assign sticky_o        = sticky_q;
  assign viol_vec_o      = vec_q;
  assign cnt_true_det_o  = cnt_arr[OC_TRUE_DET];
  assign cnt_false_pos_o = cnt_arr[OC_FALSE_POS];
  assign cnt_true_miss_o = cnt_arr[OC_TRUE_MISS];
  assign cnt_benign_o    = cnt_arr[OC_BENIGN];
endmodule

// File: rtl/impl_err_chk_sva.sv
module impl_err_chk_sva #(
  parameter int unsigned NUM_IMP = 8,
  parameter int unsigned CNT_W   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               clr_i,
  input logic               out_vld_o,
  input logic               err_o,
  input logic               sticky_o,
  input logic [NUM_IMP-1:0] viol_vec_o,
  input logic [CNT_W-1:0]   cnt_true_det_o,
  input logic [CNT_W-1:0]   cnt_false_pos_o,
  input logic [CNT_W-1:0]   cnt_true_miss_o,
  input logic [CNT_W-1:0]   cnt_benign_o
);
  // R3
  out_vld_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o == $past(valid_i));
  // R3
  err_needs_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> out_vld_o);
  // R1
  err_vec_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> (err_o == (|viol_vec_o)));
  // R1
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> $stable(viol_vec_o));
  // R4
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> sticky_o);
  // R4
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sticky_o) && !$past(clr_i)) |-> sticky_o);
  // R5
  ctr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> ($stable(cnt_true_det_o) && $stable(cnt_false_pos_o) &&
                    $stable(cnt_true_miss_o) && $stable(cnt_benign_o)));
  // R5
  ctr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cnt_true_det_o != $past(cnt_true_det_o),
                cnt_false_pos_o != $past(cnt_false_pos_o),
                cnt_true_miss_o != $past(cnt_true_miss_o),
                cnt_benign_o != $past(cnt_benign_o)}) <= 1);
  // R6
  ctr_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_true_det_o >= $past(cnt_true_det_o)) && (cnt_false_pos_o >= $past(cnt_false_pos_o)) &&
    (cnt_true_miss_o >= $past(cnt_true_miss_o)) && (cnt_benign_o >= $past(cnt_benign_o)));
endmodule

bind impl_err_chk impl_err_chk_sva #(.NUM_IMP(NUM_IMP), .CNT_W(CNT_W)) u_sva (.*);

// File: tb/tb_impl_err_chk.sv
module tb_impl_err_chk;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int NI = 8;
  localparam logic [63:0] T_ANT = {8'd2, 8'd7, 8'd4, 8'd7, 8'd6, 8'd5, 8'd4, 8'd4};
  localparam logic [63:0] T_CON = {8'd1, 8'd3, 8'd0, 8'd4, 8'd5, 8'd4, 8'd7, 8'd5};
  localparam logic [7:0]  T_AV  = 8'b1111_1011;
  localparam logic [7:0]  T_CV  = 8'b1110_0001;
  localparam logic [7:0]  EN_A  = 8'h7F;
  localparam logic [7:0]  EN_B  = 8'hFF;

  logic clk = 0, rst_ni = 0, valid = 0, mism = 0, clr = 0;
  logic [NW-1:0] nodes = '0;

  logic a_vld, a_err, a_stk; logic [NI-1:0] a_vec; logic [31:0] a_c [4];
  logic b_vld, b_err, b_stk; logic [NI-1:0] b_vec; logic [2:0]  b_c [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  impl_err_chk #(.NODE_W(NW), .NUM_IMP(NI), .CNT_W(32), .ANT_IDX(T_ANT), .CON_IDX(T_CON),
                 .ANT_VAL(T_AV), .CON_VAL(T_CV), .IMP_EN(EN_A)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .nodes_i(nodes), .out_mismatch_i(mism),
    .clr_i(clr), .out_vld_o(a_vld), .err_o(a_err), .sticky_o(a_stk), .viol_vec_o(a_vec),
    .cnt_true_det_o(a_c[0]), .cnt_false_pos_o(a_c[1]), .cnt_true_miss_o(a_c[2]),
    .cnt_benign_o(a_c[3]));

  impl_err_chk #(.NODE_W(NW), .NUM_IMP(NI), .CNT_W(3), .ANT_IDX(T_ANT), .CON_IDX(T_CON),
                 .ANT_VAL(T_AV), .CON_VAL(T_CV), .IMP_EN(EN_B)) dut_sat (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .nodes_i(nodes), .out_mismatch_i(mism),
    .clr_i(clr), .out_vld_o(b_vld), .err_o(b_err), .sticky_o(b_stk), .viol_vec_o(b_vec),
    .cnt_true_det_o(b_c[0]), .cnt_false_pos_o(b_c[1]), .cnt_true_miss_o(b_c[2]),
    .cnt_benign_o(b_c[3]));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [NI-1:0] m_vec_a = '0, m_vec_b = '0;
  logic m_stk_a = 0, m_stk_b = 0;
  longint m_cnt_a [4] = '{0, 0, 0, 0};
  longint m_cnt_b [4] = '{0, 0, 0, 0};

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] net_eval(input logic [3:0] in, input int fn, input logic fv);
    logic [NW-1:0] n;
    for (int k = 0; k < 4; k++) n[k] = (fn == k) ? fv : in[k];
    n[4] = n[0] & n[1];  if (fn == 4) n[4] = fv;
    n[5] = n[4] | n[2];  if (fn == 5) n[5] = fv;
    n[6] = ~n[5];        if (fn == 6) n[6] = fv;
    n[7] = n[6] & n[3];  if (fn == 7) n[7] = fv;
    return n;
  endfunction

  function automatic logic [NI-1:0] ref_viol(input logic [NW-1:0] n, input logic [NI-1:0] en);
    logic [NI-1:0] v;
    for (int i = 0; i < NI; i++) begin
      int ai, ci;
      ai = int'(T_ANT[i*8 +: 8]);
      ci = int'(T_CON[i*8 +: 8]);
      v[i] = en[i] && (n[ai] == T_AV[i]) && (n[ci] != T_CV[i]);
    end
    return v;
  endfunction

  function automatic int oc_idx(input logic fired, input logic mm);
    if (mm && fired) return 0;
    if (fired)       return 1;
    if (mm)          return 2;
    return 3;
  endfunction

  task automatic step(input logic v, input logic [NW-1:0] nd, input logic mm, input logic cl);
    logic [NI-1:0] ra, rb;
    logic ea, eb;
    @(negedge clk);
    valid = v; nodes = nd; mism = mm; clr = cl;
    @(posedge clk); #1;
    ra = ref_viol(nd, EN_A); rb = ref_viol(nd, EN_B);
    ea = v && (|ra); eb = v && (|rb);
    if (v) begin
      m_vec_a = ra; m_vec_b = rb;
      if (m_cnt_a[oc_idx(|ra, mm)] < 64'hFFFF_FFFF) m_cnt_a[oc_idx(|ra, mm)]++;
      if (m_cnt_b[oc_idx(|rb, mm)] < 7) m_cnt_b[oc_idx(|rb, mm)]++;
    end
    m_stk_a = (m_stk_a && !cl) || ea;
    m_stk_b = (m_stk_b && !cl) || eb;
    chk("R3", "out_vld", a_vld, v);
    chk("R3", "err", a_err, ea);
    chk("R1 R2", "viol_vec", a_vec, m_vec_a);
    chk("R4", "sticky", a_stk, m_stk_a);
    for (int k = 0; k < 4; k++) chk("R5", "count", a_c[k], m_cnt_a[k]);
    chk("R3", "sat err", b_err, eb);
    chk("R1", "sat viol_vec", b_vec, m_vec_b);
    chk("R4", "sat sticky", b_stk, m_stk_b);
    for (int k = 0; k < 4; k++) chk("R6", "sat count", b_c[k], m_cnt_b[k]);
  endtask

  task automatic fault_vec(input logic [3:0] in, input int fn, input logic fv, input logic cl);
    logic [NW-1:0] g, f;
    g = net_eval(in, 8, 1'b0);
    f = net_eval(in, fn, fv);
    step(1'b1, f, g[7] != f[7], cl);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    // R7 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "rst out_vld", a_vld, 0);
    chk("R7", "rst err", a_err, 0);
    chk("R7", "rst sticky", a_stk, 0);
    chk("R7", "rst viol_vec", a_vec, 0);
    for (int k = 0; k < 4; k++) chk("R7", "rst count", a_c[k], 0);
    @(negedge clk); rst_ni = 1;

    // fault-free cone: every enabled implication holds
    for (int i = 0; i < 16; i++) fault_vec(4'(i), 8, 1'b0, 1'b0);

    // R2: c=1,b=0 violates only the disabled entry 7; the all-enabled instance fires
    step(1'b1, net_eval(4'b0100, 8, 1'b0), 1'b0, 1'b0);
    chk("R2", "masked bit7", a_vec[7], 0);
    chk("R2", "masked err", a_err, 0);
    chk("R2", "unmasked err", b_err, 1);

    // R1 R5: n5 stuck-at-0, a=b=d=1 gives a true detection
    fault_vec(4'b1011, 5, 1'b0, 1'b0);
    // idle cycle: vec holds, no counter move (R1 R5)
    step(1'b0, '0, 1'b1, 1'b0);

    // R4: clear with no violation, then clear with a simultaneous violation
    fault_vec(4'b0000, 8, 1'b0, 1'b1);
    chk("R4", "cleared sticky", a_stk, 0);
    fault_vec(4'b1011, 5, 1'b0, 1'b0);
    fault_vec(4'b1011, 5, 1'b0, 1'b1);
    chk("R4", "set beats clear", a_stk, 1);

    // R5: true miss, n3 stuck-at-1 with n6=1 gives an output error and no violation
    fault_vec(4'b0000, 3, 1'b1, 1'b0);

    // random faults, idles and clears
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] in;
      int fn;
      logic fv, cl;
      in = 4'($urandom_range(0, 15));
      fn = int'($urandom_range(0, 8));
      fv = 1'($urandom_range(0, 1));
      cl = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) step(1'b0, net_eval(in, fn, fv), 1'b1, cl);
      else fault_vec(in, fn, fv, cl);
    end
    // R6: the narrow instance has saturated
    for (int k = 0; k < 4; k++) chk("R6", "saturated", b_c[k], 7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule